// File: doc/BRIEF.md
# Timed Power-Rail Output Sequencer

This block drives six power-control outputs of an application processor subsystem through one of four fixed step lists. Each step names one output, the level to write to it, and a hold time in milliseconds that must pass before the next step. A two-bit selector picks the list, and a one-cycle start strobe launches it. The block counts milliseconds from its clock, using a parameter that gives the number of clock cycles per millisecond.

The four lists bring the rails up from soft-off to suspend, from suspend to run, down from run to suspend, and from suspend to off. The suspend-to-off list ends by pulsing the PMIC watchdog line low long enough to pass the PMIC input filter. Between runs, every output keeps its last written level. While a list is running, `busy_o` is high. A one-cycle `done_o` pulse marks the end of the run.

The controller is a four-state machine. IDLE waits for start and latches the selector (IDLE→APPLY). APPLY writes the current step. A zero hold goes straight to the next step (APPLY→APPLY), or to FINISH on the last step. A non-zero hold loads the timer (APPLY→WAIT). WAIT stays put until the timer expires, then moves to the next step (WAIT→APPLY) or, on the last step, to FINISH (WAIT→FINISH). FINISH raises done and returns to IDLE (FINISH→IDLE).

Top module: `pwr_seqr`

## Requirements
- R1: After reset, all four rail enables are low, `cpu_rst_n_o` is low, `pmic_wdog_n_o` is high, and `busy_o` and `done_o` are low.
- R2: A start strobe sampled while idle launches the list chosen by `seq_sel_i`. `busy_o` is high from the cycle after that edge up to and including the `done_o` cycle, and low in the cycle after.
- R3: Steps are applied in list order, one step per write. The first step's output changes two clock edges after the start edge. Each later step takes effect `hold*CLK_PER_MS + 1` cycles after the previous step, so a zero hold gives the next cycle.
- R4: Selector 0 (soft-off to suspend): S3 3.3 V enable high with a 2 ms hold, then S3 1.8 V enable high with a 2 ms hold, then `cpu_rst_n_o` high with a 2 ms hold.
- R5: Selector 1 (suspend to run): S0 3.3 V enable high, then S0 1.8 V enable high, both with zero hold.
- R6: Selector 2 (run to suspend): S0 3.3 V enable low, then S0 1.8 V enable low, both with zero hold.
- R7: Selector 3 (suspend to off): `cpu_rst_n_o` low with zero hold, then S3 1.8 V enable low with a 2 ms hold, then S3 3.3 V enable low with a 2 ms hold, then `pmic_wdog_n_o` low with a 3 ms hold, then `pmic_wdog_n_o` high. The watchdog stays low for `3*CLK_PER_MS + 1` cycles, which covers a 1.6 ms PMIC filter.
- R8: `done_o` is a single-cycle pulse, once per run. It appears `hold_last*CLK_PER_MS` cycles after the last step takes effect, or in the same cycle when the last hold is zero.
- R9: A start strobe, or a selector change, that arrives while `busy_o` is high is ignored. The running list completes with unchanged timing and is not repeated.
- R10: Outputs keep their level between runs. A run changes only the outputs that its list names, and a step that writes an output's current level changes nothing. Output indices are 0 = S3 3.3 V, 1 = S3 1.8 V, 2 = S0 3.3 V, 3 = S0 1.8 V, 4 = processor reset, 5 = watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch strobe, sampled only when idle |
| seq_sel_i | input | 2 | List select: 0 soft-off→suspend, 1 suspend→run, 2 run→suspend, 3 suspend→off |
| busy_o | output | 1 | High while a list runs |
| done_o | output | 1 | One-cycle end-of-run pulse |
| s3_3v3_en_o | output | 1 | S3 3.3 V rail enable |
| s3_1v8_en_o | output | 1 | S3 1.8 V rail enable |
| s0_3v3_en_o | output | 1 | S0 3.3 V rail enable |
| s0_1v8_en_o | output | 1 | S0 1.8 V rail enable |
| cpu_rst_n_o | output | 1 | Active-low processor reset |
| pmic_wdog_n_o | output | 1 | Active-low PMIC watchdog |

## Verification
A wrong step index or a wrong latched selector shows at the rail pins as a wrong output, or a right output at the wrong level, at the very edge where that step is written. A timer that runs short or long moves every later output edge, and the `done_o` pulse, by a fixed number of cycles. The bench therefore timestamps every output transition and the done pulse, and compares each against the cycle computed from the list. A machine that restarts on a stray strobe shows as extra transitions or a second done pulse, which the exact event count catches within the run.

// File: rtl/pwr_seqr_pkg.sv
package pwr_seqr_pkg;

    localparam int NUM_OUT = 6;
    localparam int STEP_W  = 3;

    localparam logic [7:0] OI_S3_3V3 = 8'd0;
    localparam logic [7:0] OI_S3_1V8 = 8'd1;
    localparam logic [7:0] OI_S0_3V3 = 8'd2;
    localparam logic [7:0] OI_S0_1V8 = 8'd3;
    localparam logic [7:0] OI_CPURST = 8'd4;
    localparam logic [7:0] OI_WDOG   = 8'd5;

    typedef struct packed {
        logic [7:0] idx;
        logic       lvl;
        logic [7:0] dly;
    } seq_step_t;

    function automatic seq_step_t mk(logic [7:0] i, logic l, logic [7:0] d);
        seq_step_t s;
        s.idx = i;
        s.lvl = l;
        s.dly = d;
        return s;
    endfunction

    function automatic logic [STEP_W-1:0] list_len(logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd3;
            2'd1:    return 3'd2;
            2'd2:    return 3'd2;
            default: return 3'd5;
        endcase
    endfunction

    function automatic seq_step_t step_of(logic [1:0] sel, logic [STEP_W-1:0] st);
        case ({sel, st})
            {2'd0, 3'd0}: return mk(OI_S3_3V3, 1'b1, 8'd2);
            {2'd0, 3'd1}: return mk(OI_S3_1V8, 1'b1, 8'd2);
            {2'd0, 3'd2}: return mk(OI_CPURST, 1'b1, 8'd2);
            {2'd1, 3'd0}: return mk(OI_S0_3V3, 1'b1, 8'd0);
            {2'd1, 3'd1}: return mk(OI_S0_1V8, 1'b1, 8'd0);
            {2'd2, 3'd0}: return mk(OI_S0_3V3, 1'b0, 8'd0);
            {2'd2, 3'd1}: return mk(OI_S0_1V8, 1'b0, 8'd0);
            {2'd3, 3'd0}: return mk(OI_CPURST, 1'b0, 8'd0);
            {2'd3, 3'd1}: return mk(OI_S3_1V8, 1'b0, 8'd2);
            {2'd3, 3'd2}: return mk(OI_S3_3V3, 1'b0, 8'd2);
            {2'd3, 3'd3}: return mk(OI_WDOG,   1'b0, 8'd3);
            {2'd3, 3'd4}: return mk(OI_WDOG,   1'b1, 8'd0);
            default:      return mk(8'hFF, 1'b0, 8'd0);
        endcase
    endfunction

endpackage

// File: rtl/pwr_seqr_table.sv
module pwr_seqr_table
    import pwr_seqr_pkg::*;
(
    input  logic [1:0]        sel_i,
    input  logic [STEP_W-1:0] step_i,
    output seq_step_t         step_o,
    output logic              last_o
);
    always_comb begin
        step_o = step_of(sel_i, step_i);
        last_o = (step_i == (list_len(sel_i) - 3'd1));
    end
endmodule

// File: rtl/pwr_seqr_timer.sv
module pwr_seqr_timer #(
    parameter int CLK_PER_MS = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] ms_i,
    output logic       expire_o
);
    localparam int TW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(CLK_PER_MS - 1);

    logic [TW-1:0] tick_q;
    logic [7:0]    ms_left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q    <= '0;
            ms_left_q <= '0;
        end else if (load_i) begin
            tick_q    <= '0;
            ms_left_q <= ms_i;
        end else if (ms_left_q != 8'd0) begin
            if (tick_q == TICK_LAST) begin
                tick_q    <= '0;
                ms_left_q <= ms_left_q - 8'd1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign expire_o = (ms_left_q == 8'd1) && (tick_q == TICK_LAST);

    // R3: an expiry is a single event; the count is empty after it
    p_expire_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o && !load_i |=> !expire_o);

    // R3: a load with a non-zero hold cannot expire in the next cycle unless the hold is one tick
    p_load_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && (ms_i > 8'd1) |=> !expire_o);
endmodule

// File: rtl/pwr_seqr_outs.sv
module pwr_seqr_outs #(
    parameter int                 NUM_OUT = 6,
    parameter logic [NUM_OUT-1:0] RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [7:0]         idx_i,
    input  logic               lvl_i,
    output logic [NUM_OUT-1:0] q_o
);
    logic [NUM_OUT-1:0] hit;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_bit
        assign hit[g] = we_i && (idx_i == 8'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_o[g] <= RST_VAL[g];
            else if (hit[g])
                q_o[g] <= lvl_i;
        end
    end

    // R10: at most one output is addressed by a write
    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R10: without a write every output holds its level
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q_o));
endmodule

// File: rtl/pwr_seqr.sv
module pwr_seqr
    import pwr_seqr_pkg::*;
#(
    parameter int CLK_PER_MS = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] seq_sel_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       s3_3v3_en_o,
    output logic       s3_1v8_en_o,
    output logic       s0_3v3_en_o,
    output logic       s0_1v8_en_o,
    output logic       cpu_rst_n_o,
    output logic       pmic_wdog_n_o
);
    localparam logic [NUM_OUT-1:0] OUT_RST = 6'b100000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_APPLY,
        ST_WAIT,
        ST_FINISH
    } st_e;

    st_e               state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [1:0]        sel_q, sel_d;

    seq_step_t         cur;
    logic              cur_last;
    logic              tmr_expire;
    logic              wr_en;
    logic              tmr_load;
    logic [NUM_OUT-1:0] outs;

    pwr_seqr_table u_table (
        .sel_i  (sel_q),
        .step_i (step_q),
        .step_o (cur),
        .last_o (cur_last)
    );

    pwr_seqr_timer #(.CLK_PER_MS(CLK_PER_MS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .ms_i     (cur.dly),
        .expire_o (tmr_expire)
    );

    pwr_seqr_outs #(.NUM_OUT(NUM_OUT), .RST_VAL(OUT_RST)) u_outs (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wr_en),
        .idx_i (cur.idx),
        .lvl_i (cur.lvl),
        .q_o   (outs)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            sel_q   <= sel_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_APPLY;
                    step_d  = '0;
                    sel_d   = seq_sel_i;
                end
            end
            ST_APPLY: begin
                if (cur.dly != 8'd0) begin
                    state_d = ST_WAIT;
                end else if (cur_last) begin
                    state_d = ST_FINISH;
                end else begin
                    step_d = step_q + 3'd1;
                end
            end
            ST_WAIT: begin
                if (tmr_expire) begin
                    if (cur_last) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_APPLY;
                        step_d  = step_q + 3'd1;
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        tmr_load = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_APPLY: begin
                wr_en    = 1'b1;
                tmr_load = (cur.dly != 8'd0);
            end
            ST_WAIT:   ;
            ST_FINISH: done_o = 1'b1;
        endcase
    end

    assign s3_3v3_en_o   = outs[0];
    assign s3_1v8_en_o   = outs[1];
    assign s0_3v3_en_o   = outs[2];
    assign s0_1v8_en_o   = outs[3];
    assign cpu_rst_n_o   = outs[4];
    assign pmic_wdog_n_o = outs[5];

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: busy only falls right after done
    p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    // R2: a start while idle begins at the first step
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && start_i |=> (state_q == ST_APPLY) && (step_q == '0) && busy_o);

    // R9: the selected list cannot change during a run
    p_sel_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> $stable(sel_q) && busy_o);

    // R3: waiting continues until the timer expires
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) && !tmr_expire |=> (state_q == ST_WAIT) && $stable(step_q));
endmodule

// File: tb/pwr_seqr_tb.sv
module pwr_seqr_tb;
    localparam int CPM = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       busy, done;
    logic       s3_33, s3_18, s0_33, s0_18, crst_n, wdog_n;

    pwr_seqr #(.CLK_PER_MS(CPM)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .seq_sel_i     (sel),
        .busy_o        (busy),
        .done_o        (done),
        .s3_3v3_en_o   (s3_33),
        .s3_1v8_en_o   (s3_18),
        .s0_3v3_en_o   (s0_33),
        .s0_1v8_en_o   (s0_18),
        .cpu_rst_n_o   (crst_n),
        .pmic_wdog_n_o (wdog_n)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [5:0] obs;
    assign obs = {wdog_n, crst_n, s0_18, s0_33, s3_18, s3_33};

    logic [5:0] prev = 6'b0;
    int ev_cyc[256];
    int ev_bit[256];
    int ev_val[256];
    int ev_n = 0;
    int done_n = 0;
    int done_at = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev = obs;
        end else begin
            for (int b = 0; b < 6; b++) begin
                if (obs[b] != prev[b] && ev_n < 256) begin
                    ev_cyc[ev_n] = cyc;
                    ev_bit[ev_n] = b;
                    ev_val[ev_n] = int'(obs[b]);
                    ev_n = ev_n + 1;
                end
            end
            prev = obs;
            if (done) begin
                done_n  = done_n + 1;
                done_at = cyc;
            end
        end
    end

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [5:0] mdl = 6'b100000;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bench model of the lists, written from the requirements
    function automatic int lst_len(input int s);
        case (s)
            0: return 3;
            1: return 2;
            2: return 2;
            default: return 5;
        endcase
    endfunction

    task automatic lst_step(input int s, input int i, output int idx, output int lvl, output int dly);
        idx = 0; lvl = 0; dly = 0;
        case (s)
            0: case (i)
                   0: begin idx = 0; lvl = 1; dly = 2; end
                   1: begin idx = 1; lvl = 1; dly = 2; end
                   default: begin idx = 4; lvl = 1; dly = 2; end
               endcase
            1: case (i)
                   0: begin idx = 2; lvl = 1; dly = 0; end
                   default: begin idx = 3; lvl = 1; dly = 0; end
               endcase
            2: case (i)
                   0: begin idx = 2; lvl = 0; dly = 0; end
                   default: begin idx = 3; lvl = 0; dly = 0; end
               endcase
            default: case (i)
                   0: begin idx = 4; lvl = 0; dly = 0; end
                   1: begin idx = 1; lvl = 0; dly = 2; end
                   2: begin idx = 0; lvl = 0; dly = 2; end
                   3: begin idx = 5; lvl = 0; dly = 3; end
                   default: begin idx = 5; lvl = 1; dly = 0; end
               endcase
        endcase
    endtask

    task automatic run_seq(input int s, input bit noise, input string req);
        int base, dbase, n0, t, k, ecnt, done_exp, wlo, whi;
        int ecyc[8];
        int ebit[8];
        int eval[8];
        base = ev_n;
        dbase = done_n;
        wlo = -1;
        whi = -1;
        @(negedge clk);
        n0 = cyc;
        start = 1'b1;
        sel = 2'(s);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        t = n0 + 2;
        ecnt = 0;
        for (int i = 0; i < lst_len(s); i++) begin
            int idx, lvl, dly;
            lst_step(s, i, idx, lvl, dly);
            if (int'(mdl[idx]) != lvl) begin
                ecyc[ecnt] = t;
                ebit[ecnt] = idx;
                eval[ecnt] = lvl;
                ecnt++;
            end
            mdl[idx] = lvl[0];
            t = t + dly * CPM + 1;
        end
        done_exp = t - 1;
        k = 0;
        while (!done && k < 2000) begin
            @(negedge clk);
            if (noise && !done) begin
                start = (k % 4 == 1);
                sel = ~2'(s);
            end else begin
                start = 1'b0;
            end
            k++;
        end
        start = 1'b0;
        sel = 2'(s);
        chk(done == 1'b1, "R8", "done seen", int'(done), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R2", "busy after done", int'(busy), 0);
        chk(done == 1'b0, "R8", "done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        chk(ev_n - base == ecnt, "R3", "transition count", ev_n - base, ecnt);
        for (int i = 0; i < ecnt; i++) begin
            if (base + i < ev_n) begin
                chk(ev_bit[base+i] == ebit[i], req, "output index", ev_bit[base+i], ebit[i]);
                chk(ev_val[base+i] == eval[i], req, "output level", ev_val[base+i], eval[i]);
                chk(ev_cyc[base+i] == ecyc[i], "R3", "step cycle", ev_cyc[base+i], ecyc[i]);
                if (ev_bit[base+i] == 5 && ev_val[base+i] == 0) wlo = ev_cyc[base+i];
                if (ev_bit[base+i] == 5 && ev_val[base+i] == 1) whi = ev_cyc[base+i];
            end
        end
        chk(done_n - dbase == 1, "R8", "done pulses per run", done_n - dbase, 1);
        chk(done_at == done_exp, "R8", "done cycle", done_at, done_exp);
        if (s == 3)
            chk(whi - wlo == 3 * CPM + 1, "R7", "watchdog low width", whi - wlo, 3 * CPM + 1);
        chk(obs == mdl, req, "final outputs", int'(obs), int'(mdl));
    endtask

    task automatic check_reset();
        repeat (3) @(negedge clk);
        chk(obs == 6'b100000, "R1", "outputs at reset", int'(obs), 32);
        chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done at reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(obs == 6'b100000, "R1", "outputs after release", int'(obs), 32);
    endtask

    task automatic check_hold();
        int base;
        base = ev_n;
        repeat (40) @(negedge clk);
        chk(ev_n == base, "R10", "idle transitions", ev_n - base, 0);
        chk(obs == mdl, "R10", "idle outputs", int'(obs), int'(mdl));
        chk(busy == 1'b0, "R10", "idle busy", int'(busy), 0);
    endtask

    initial begin
        check_reset();
        run_seq(0, 1'b0, "R4");
        run_seq(1, 1'b0, "R5");
        check_hold();
        run_seq(2, 1'b0, "R6");
        run_seq(3, 1'b0, "R7");
        run_seq(2, 1'b0, "R10");
        check_hold();
        run_seq(0, 1'b1, "R9");
        run_seq(1, 1'b1, "R9");
        run_seq(2, 1'b0, "R6");
        run_seq(3, 1'b1, "R9");
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not end actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule